// File: doc/BRIEF.md
# Instruction-Address Breakpoint Table

The block holds a small, fixed number of instruction-address breakpoints and compares every stored address with the current fetch address on each cycle. A single command port lets a debug controller insert an address or delete one. Each command takes one clock edge and is acknowledged with a one-cycle completion pulse that carries a success flag.

A slot that holds zero is free, so address zero can never be a breakpoint. Insertion uses the lowest-numbered free slot. Deletion removes every copy of the given address and slides the remaining entries toward slot 0 in their original order, so occupied slots always form a contiguous run starting at slot 0. A global enable output is raised by any successful insertion and falls by itself when a deletion leaves the table empty. The hit output is gated by that enable.

Top module: `bp_table`

## Requirements
- R1: After reset every slot is free, and `bp_enabled`, `bp_hit`, `cmd_done` and `cmd_ok` are all 0.
- R2: A command is taken on a rising edge where `cmd_valid` is 1 (`cmd_op` 0 = insert, 1 = delete). `cmd_done` is 1 during the cycle that follows each accepted command and 0 after any cycle without one. `cmd_ok` is valid while `cmd_done` is 1.
- R3: An insert of a nonzero address writes it into the lowest-numbered free slot, returns `cmd_ok`=1 and sets `bp_enabled`. An address already present may be stored again in a further slot.
- R4: An insert while every slot is occupied, or an insert of address zero, returns `cmd_ok`=0 and leaves the table and `bp_enabled` unchanged.
- R5: A delete removes every slot equal to the nonzero address. Surviving entries move down in their original order, and the freed slots at the top become zero, so the full capacity is available again. `cmd_ok`=1 when at least one slot was removed.
- R6: A delete of an address that is not stored, or of zero, returns `cmd_ok`=0 and changes nothing.
- R7: When a delete leaves all slots free, `bp_enabled` goes to 0. Otherwise it stays 1.
- R8: `bp_hit` is 1 in the same cycle exactly when `bp_enabled` is 1, `fetch_pc` is nonzero and `fetch_pc` equals some stored slot.
- R9: In cycles without a command, the table contents and `bp_enabled` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 = insert, 1 = delete |
| cmd_addr | input | AW (64) | Breakpoint address of the command |
| fetch_pc | input | AW (64) | Current fetch address |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_ok | output | 1 | Success of the completed command |
| bp_enabled | output | 1 | Global breakpoint enable |
| bp_hit | output | 1 | Fetch address matches an active breakpoint |

## Verification
The bench targets duplicate entries: a delete that stopped after the first copy would leave a later copy still producing hits. It also targets capacity after a delete from the middle of a full table. Without compaction, or with a stale top slot, the next inserts would fail too early or land in the wrong place. Further corner cases are the insert and delete of address zero, an insert into a full table, and a delete of an absent address. Each of these must report failure and leave the table untouched. The last checks are that the enable falls only when the final entry goes, and that a fetch address of zero never hits.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
   typedef enum logic {
      BPT_INSERT = 1'b0,
      BPT_DELETE = 1'b1
   } bpt_op_e;
endpackage

// File: rtl/bpt_match.sv
module bpt_match #(
   parameter int AW    = 64,
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0][AW-1:0] slots,
   input  logic [AW-1:0]            key,
   output logic [DEPTH-1:0]         eq
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign eq[i] = (slots[i] == key);
   end
endmodule

// File: rtl/bpt_first_free.sv
module bpt_first_free #(
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0] empty,
   output logic [DEPTH-1:0] pick,
   output logic             any
);
   always_comb begin
      logic seen;
      seen = 1'b0;
      pick = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (empty[i] && !seen) begin
            pick[i] = 1'b1;
            seen    = 1'b1;
         end
      end
      any = seen;
   end
endmodule

// File: rtl/bpt_compact.sv
module bpt_compact #(
   parameter int AW    = 64,
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0][AW-1:0] slots,
   input  logic [DEPTH-1:0]         keep,
   output logic [DEPTH-1:0][AW-1:0] packed_slots
);
   localparam int IW = $clog2(DEPTH);

   always_comb begin
      logic [IW:0] cnt;
      cnt          = '0;
      packed_slots = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (keep[i]) begin
            packed_slots[cnt[IW-1:0]] = slots[i];
            cnt = cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bp_table.sv
module bp_table #(
   parameter int AW      = 64,
   parameter int DEPTH   = 8,
   parameter bit REG_HIT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic          cmd_op,
   input  logic [AW-1:0] cmd_addr,
   input  logic [AW-1:0] fetch_pc,
   output logic          cmd_done,
   output logic          cmd_ok,
   output logic          bp_enabled,
   output logic          bp_hit
);
   import bpt_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("bp_table: DEPTH must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("bp_table: AW must be at least 2");
   end

   logic [DEPTH-1:0][AW-1:0] slots_q, slots_d, slots_ins, slots_pack;
   logic [DEPTH-1:0]         empty, eq_cmd, eq_pc, pick;
   logic                     free_any, en_d, ok_d, done_q, ok_q, en_q;
   logic                     addr_nz, pack_nonempty, hit_raw;
   bpt_op_e                  op;

   assign op      = bpt_op_e'(cmd_op);
   assign addr_nz = (cmd_addr != '0);

   for (genvar i = 0; i < DEPTH; i++) begin : g_empty
      assign empty[i] = (slots_q[i] == '0);
   end

   bpt_match #(.AW(AW), .DEPTH(DEPTH)) u_cmd_match (
      .slots(slots_q), .key(cmd_addr), .eq(eq_cmd));

   bpt_match #(.AW(AW), .DEPTH(DEPTH)) u_pc_match (
      .slots(slots_q), .key(fetch_pc), .eq(eq_pc));

   bpt_first_free #(.DEPTH(DEPTH)) u_free (
      .empty(empty), .pick(pick), .any(free_any));

   bpt_compact #(.AW(AW), .DEPTH(DEPTH)) u_pack (
      .slots(slots_q), .keep(~eq_cmd), .packed_slots(slots_pack));

   for (genvar i = 0; i < DEPTH; i++) begin : g_ins
      assign slots_ins[i] = pick[i] ? cmd_addr : slots_q[i];
   end

   assign pack_nonempty = (slots_pack != '0);

   always_comb begin
      slots_d = slots_q;
      en_d    = en_q;
      ok_d    = 1'b0;
      if (cmd_valid) begin
         unique case (op)
            BPT_INSERT: begin
               if (addr_nz && free_any) begin
                  ok_d    = 1'b1;
                  slots_d = slots_ins;
                  en_d    = 1'b1;
               end
            end
            BPT_DELETE: begin
               if (addr_nz && (eq_cmd != '0)) begin
                  ok_d    = 1'b1;
                  slots_d = slots_pack;
                  en_d    = pack_nonempty;
               end
            end
            default: ok_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slots_q <= '0;
         en_q    <= 1'b0;
         done_q  <= 1'b0;
         ok_q    <= 1'b0;
      end else begin
         slots_q <= slots_d;
         en_q    <= en_d;
         done_q  <= cmd_valid;
         ok_q    <= ok_d;
      end
   end

   assign hit_raw = en_q && (fetch_pc != '0) && (eq_pc != '0);

   if (REG_HIT) begin : g_hit_reg
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= hit_raw;
      end
      assign bp_hit = hit_q;
   end else begin : g_hit_comb
      assign bp_hit = hit_raw;
   end

   assign cmd_done   = done_q;
   assign cmd_ok     = ok_q;
   assign bp_enabled = en_q;
endmodule

// File: rtl/bp_table_chk.sv
module bp_table_chk #(
   parameter int AW      = 64,
   parameter int DEPTH   = 8,
   parameter bit REG_HIT = 1'b0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cmd_valid,
   input logic                     cmd_op,
   input logic [AW-1:0]            cmd_addr,
   input logic [AW-1:0]            fetch_pc,
   input logic                     cmd_done,
   input logic                     cmd_ok,
   input logic                     bp_enabled,
   input logic                     bp_hit,
   input logic [DEPTH-1:0][AW-1:0] slots_q
);
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> cmd_done);

   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !cmd_done);

   a_r3_insert_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_op) |=> (!cmd_ok || bp_enabled));

   a_r4_zero_insert: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_op && cmd_addr == '0) |=> (!cmd_ok && $stable(slots_q)));

   a_r4_full_insert: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_op && slots_q[DEPTH-1] != '0) |=> (!cmd_ok && $stable(slots_q)));

   a_r7_enable_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
      bp_enabled == (slots_q[0] != '0));

   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(slots_q) && $stable(bp_enabled)));

   for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_packed
      a_r5_packed: assert property (@(posedge clk) disable iff (!rst_n)
         (slots_q[i] == '0) |-> (slots_q[i+1] == '0));
   end

   if (REG_HIT) begin : g_hit_reg
      a_r8_hit_gated: assert property (@(posedge clk) disable iff (!rst_n)
         bp_hit |-> $past(bp_enabled));
   end else begin : g_hit_comb
      a_r8_hit_gated: assert property (@(posedge clk) disable iff (!rst_n)
         bp_hit |-> (bp_enabled && fetch_pc != '0));
   end
endmodule

bind bp_table bp_table_chk #(.AW(AW), .DEPTH(DEPTH), .REG_HIT(REG_HIT)) u_chk (.*);

// File: tb/bp_table_bench.sv
module bp_table_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 64;
   localparam int DEPTH      = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_op = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [AW-1:0] fetch_pc = '0;
   logic          cmd_done, cmd_ok, bp_enabled, bp_hit;

   int            n_checks = 0;
   int            n_errors = 0;
   logic [AW-1:0] model [DEPTH];
   logic [AW-1:0] last_rand = 64'h1;

   always #(CLK_PERIOD/2) clk = ~clk;

   bp_table #(.AW(AW), .DEPTH(DEPTH)) u_bp_table (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .fetch_pc(fetch_pc), .cmd_done(cmd_done),
      .cmd_ok(cmd_ok), .bp_enabled(bp_enabled), .bp_hit(bp_hit));

   task automatic check(input bit good, input string req,
                        input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (!good) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit model_en();
      bit e = 1'b0;
      for (int i = 0; i < DEPTH; i++) if (model[i] != '0) e = 1'b1;
      return e;
   endfunction

   function automatic bit model_hit(input logic [AW-1:0] pc);
      bit h = 1'b0;
      for (int i = 0; i < DEPTH; i++) if (model[i] == pc) h = 1'b1;
      return model_en() && pc != '0 && h;
   endfunction

   function automatic bit model_insert(input logic [AW-1:0] a);
      if (a == '0) return 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (model[i] == '0) begin
            model[i] = a;
            return 1'b1;
         end
      end
      return 1'b0;
   endfunction

   function automatic bit model_delete(input logic [AW-1:0] a);
      logic [AW-1:0] tmp [DEPTH];
      int k = 0;
      bit found = 1'b0;
      if (a == '0) return 1'b0;
      for (int i = 0; i < DEPTH; i++) tmp[i] = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (model[i] == a) found = 1'b1;
         else begin
            tmp[k] = model[i];
            k++;
         end
      end
      if (found) for (int i = 0; i < DEPTH; i++) model[i] = tmp[i];
      return found;
   endfunction

   function automatic logic [AW-1:0] pick_addr();
      int unsigned r = $urandom % 16;
      if (r < 10)       return AW'(r + 1);
      else if (r < 13)  return {32'hFFFF_FFFF, 32'(r)};
      else if (r == 13) return '0;
      else              return {$urandom, $urandom};
   endfunction

   // Issue one command and check its completion (R2) and result.
   task automatic do_cmd(input bit op, input logic [AW-1:0] a, input string req);
      bit exp_ok;
      exp_ok = op ? model_delete(a) : model_insert(a);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = a;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(cmd_done == 1'b1, "R2 done pulse", AW'(cmd_done), 1);
      check(cmd_ok == exp_ok, req, AW'(cmd_ok), AW'(exp_ok));
      check(bp_enabled == model_en(), "R7 enable", AW'(bp_enabled), AW'(model_en()));
   endtask

   task automatic probe(input logic [AW-1:0] pc, input string req);
      fetch_pc = pc;
      #1;
      check(bp_hit == model_hit(pc), req, AW'(bp_hit), AW'(model_hit(pc)));
   endtask

   // Look at every interesting address: hits reveal the stored contents (R5, R9).
   task automatic probe_all(input string req);
      for (int v = 0; v <= 10; v++) probe(AW'(v), req);
      for (int v = 10; v < 13; v++) probe({32'hFFFF_FFFF, 32'(v)}, req);
      probe(last_rand, req);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      void'($urandom(32'd5171));
      #(CLK_PERIOD * 2);
      @(negedge clk);
      check(bp_enabled == 1'b0, "R1 enable at reset", AW'(bp_enabled), 0);
      check(cmd_done == 1'b0, "R1 done at reset", AW'(cmd_done), 0);
      check(cmd_ok == 1'b0, "R1 ok at reset", AW'(cmd_ok), 0);
      probe(64'd3, "R1 hit at reset");
      rst_n = 1'b1;
      @(negedge clk);
      probe_all("R1 empty after reset");

      // Fill the table, then overflow it (R3, R4).
      for (int v = 1; v <= DEPTH; v++) do_cmd(1'b0, AW'(v), "R3 insert");
      probe_all("R3 hits after fill");
      do_cmd(1'b0, 64'd9, "R4 insert into full table");
      probe(64'd9, "R4 rejected address absent");
      do_cmd(1'b0, 64'd0, "R4 insert of zero");
      @(negedge clk);
      check(cmd_done == 1'b0, "R2 done only one cycle", AW'(cmd_done), 0);

      // Delete from the middle, capacity returns by exactly one (R5).
      do_cmd(1'b1, 64'd3, "R5 delete middle");
      probe_all("R5 after middle delete");
      do_cmd(1'b0, 64'd9, "R5 insert after compaction");
      do_cmd(1'b0, 64'd10, "R5 full again after one insert");
      probe_all("R5 contents after refill");

      // Absent and zero deletes (R6).
      do_cmd(1'b1, 64'd10, "R6 delete absent");
      do_cmd(1'b1, 64'd0, "R6 delete zero");
      probe_all("R6 unchanged");

      // Empty it, with the enable falling only at the end (R7).
      for (int v = 1; v <= 9; v++) do_cmd(1'b1, AW'(v), "R7 drain");
      probe_all("R7 empty table");

      // Duplicates are all removed by one delete (R3, R5).
      do_cmd(1'b0, 64'd5, "R3 dup insert");
      do_cmd(1'b0, 64'd5, "R3 dup insert");
      do_cmd(1'b0, 64'd7, "R3 dup insert");
      do_cmd(1'b0, 64'd5, "R3 dup insert");
      do_cmd(1'b1, 64'd5, "R5 delete all copies");
      probe_all("R5 copies gone");
      do_cmd(1'b1, 64'd7, "R7 last entry removed");
      probe(64'd7, "R8 no hit when disabled");

      // Random mix (R3..R9).
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] a;
         bit            op;
         a  = pick_addr();
         op = ($urandom % 5) < 2;
         if (a[AW-1:32] != '0 && a[AW-1:32] != 32'hFFFF_FFFF) last_rand = a;
         do_cmd(op, a, op ? "R5 random delete" : "R3 random insert");
         if ((n % 4) == 0) begin
            @(negedge clk);
            check(cmd_done == 1'b0, "R9 idle cycle no done", AW'(cmd_done), 0);
         end
         probe_all("R8 random hit");
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule